// File: doc/BRIEF.md
# Dual-Port RAM with Address-Contention Arbiter

A clocked memory of 8192 bytes with two identical ports, left and right. Each port carries a chip enable, a write strobe, an output enable, a 13-bit address, write data and registered read data. Either port can reach every location. When both ports are enabled on the same address, an arbiter grants the port that was there first and raises a busy flag toward the other port. The busy flag blocks that port's writes until the contention ends.

A mode input selects the busy source. As master, the internal arbiter decides the grant and drives the busy outputs. As slave, the busy outputs stay low and busy inputs from an external master block writes instead. Several devices can then be cascaded for width under one arbiter.

Reads are never blocked by busy. Write strobes are sampled every cycle, so a write held off by busy lands in the first cycle its port is no longer busy.

Top module: `dpram_contend`

## Requirements
- R1: Every location can be written from either port and read back from the other port.
- R2: When both ports are enabled and the addresses come to match, the port that was already enabled at that address in the previous cycle wins. The other port's busy output goes high in the same cycle. This holds in either direction.
- R3: When the addresses already match and one port's chip enable rises while the other port is enabled, the port that rises later is busy.
- R4: When both ports reach the matching address in the same cycle, the left port wins and only the right busy output is high. The two busy outputs are never high together.
- R5: A busy port's write leaves the array unchanged. Reads on a busy port still return the array contents.
- R6: A write held off by busy is stored in the first cycle after busy falls in which the port still presents it.
- R7: Busy falls in the same cycle that the addresses stop matching, or in the same cycle that the winning port's chip enable goes low.
- R8: While the match persists, the grant and the busy output do not change, even when the winner drops its write strobe.
- R9: With `master_i` low, both busy outputs stay low. A high `l_busy_i` or `r_busy_i` inhibits writes on its port exactly as an internal busy would. The internal arbitration has no effect.
- R10: Read data is registered, and the read enable is chip enable and output enable high with the write strobe low. A read that shares a cycle and an address with the other port's write returns the old data; the next cycle's read returns the new data.
- R11: After reset, both read data outputs are zero and both busy outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_i | input | 1 | 1 = internal arbiter drives busy, 0 = busy taken from inputs |
| l_ce_i | input | 1 | Left chip enable, active high |
| l_we_i | input | 1 | Left write strobe, active high |
| l_oe_i | input | 1 | Left output enable, active high |
| l_addr_i | input | ADDR_W | Left address |
| l_wdata_i | input | DATA_W | Left write data |
| l_rdata_o | output | DATA_W | Left registered read data |
| l_busy_o | output | 1 | Left busy from the internal arbiter (master mode) |
| l_busy_i | input | 1 | Left busy from an external master (slave mode) |
| r_ce_i | input | 1 | Right chip enable, active high |
| r_we_i | input | 1 | Right write strobe, active high |
| r_oe_i | input | 1 | Right output enable, active high |
| r_addr_i | input | ADDR_W | Right address |
| r_wdata_i | input | DATA_W | Right write data |
| r_rdata_o | output | DATA_W | Right registered read data |
| r_busy_o | output | 1 | Right busy from the internal arbiter (master mode) |
| r_busy_i | input | 1 | Right busy from an external master (slave mode) |

## Verification
The functions that collide are a write on one port and a read or write on the other port at the same address in the same cycle. The bench provokes this by walking every address of a 16-entry configuration with one port parked and the other arriving. It also makes both ports arrive together, both through chip enables and through address moves. Each case is judged at the ports: the busy outputs are sampled in the arrival cycle, and the array is read back afterwards to prove which write landed. A same-cycle read against the other port's write is checked for old data and then for new data one cycle later.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    localparam int NPORT  = 2;
    localparam int PORT_L = 0;
    localparam int PORT_R = 1;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef struct packed {
        logic ce;
        logic we;
        logic oe;
    } ctl_t;

    // Earlier arrival wins; a tie (or no history) goes to the left port.
    function automatic owner_e pick_winner(logic l_was_here, logic r_was_here);
        if (r_was_here && !l_was_here) return OWN_RIGHT;
        return OWN_LEFT;
    endfunction

endpackage

// File: rtl/dpram_arbiter.sv
module dpram_arbiter
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NPORT-1:0]              ce_i,
    input  logic [NPORT-1:0][ADDR_W-1:0]  addr_i,
    output logic                          match_o,
    output logic [NPORT-1:0]              lose_o
);

    logic [NPORT-1:0]             ce_q;
    logic [NPORT-1:0][ADDR_W-1:0] addr_q;
    logic [NPORT-1:0]             was_here;
    owner_e                       owner_q, owner_d;

    assign match_o = (&ce_i) && (addr_i[PORT_L] == addr_i[PORT_R]);

    // A port "was here" if it sat enabled on the now-shared address last cycle.
    for (genvar p = 0; p < NPORT; p++) begin : g_hist
        assign was_here[p] = ce_q[p] && (addr_q[p] == addr_i[PORT_L]);
    end

    always_comb begin
        if (!match_o)
            owner_d = OWN_NONE;
        else if (owner_q != OWN_NONE)
            owner_d = owner_q;
        else
            owner_d = pick_winner(was_here[PORT_L], was_here[PORT_R]);
    end

    assign lose_o[PORT_L] = match_o && (owner_d == OWN_RIGHT);
    assign lose_o[PORT_R] = match_o && (owner_d == OWN_LEFT);

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q <= OWN_NONE;
            ce_q    <= '0;
            addr_q  <= '0;
        end else begin
            owner_q <= owner_d;
            ce_q    <= ce_i;
            addr_q  <= addr_i;
        end
    end

endmodule

// File: rtl/dpram_port_ctl.sv
module dpram_port_ctl
    import dpram_pkg::*;
(
    input  ctl_t ctl_i,
    input  logic busy_i,
    output logic wr_en_o,
    output logic rd_en_o
);

    assign wr_en_o = ctl_i.ce && ctl_i.we && !busy_i;
    assign rd_en_o = ctl_i.ce && ctl_i.oe && !ctl_i.we;

endmodule

// File: rtl/dpram_core.sv
module dpram_core
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NPORT-1:0]              wr_en_i,
    input  logic [NPORT-1:0]              rd_en_i,
    input  logic [NPORT-1:0][ADDR_W-1:0]  addr_i,
    input  logic [NPORT-1:0][DATA_W-1:0]  wdata_i,
    output logic [NPORT-1:0][DATA_W-1:0]  rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Right is written first so that left prevails if both ever land together.
    always_ff @(posedge clk) begin
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (wr_en_i[p]) mem[addr_i[p]] <= wdata_i[p];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_o <= '0;
        end else begin
            for (int p = 0; p < NPORT; p++) begin
                if (rd_en_i[p]) rdata_o[p] <= mem[addr_i[p]];
            end
        end
    end

endmodule

// File: rtl/dpram_contend.sv
module dpram_contend
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              master_i,
    input  logic              l_ce_i,
    input  logic              l_we_i,
    input  logic              l_oe_i,
    input  logic [ADDR_W-1:0] l_addr_i,
    input  logic [DATA_W-1:0] l_wdata_i,
    output logic [DATA_W-1:0] l_rdata_o,
    output logic              l_busy_o,
    input  logic              l_busy_i,
    input  logic              r_ce_i,
    input  logic              r_we_i,
    input  logic              r_oe_i,
    input  logic [ADDR_W-1:0] r_addr_i,
    input  logic [DATA_W-1:0] r_wdata_i,
    output logic [DATA_W-1:0] r_rdata_o,
    output logic              r_busy_o,
    input  logic              r_busy_i
);

    logic [NPORT-1:0]             ce_v, we_v, oe_v, busy_ext, lose_v, busy_eff;
    logic [NPORT-1:0]             wr_en, rd_en;
    logic [NPORT-1:0][ADDR_W-1:0] addr_v;
    logic [NPORT-1:0][DATA_W-1:0] wdata_v, rdata_v;
    logic                         match_w;

    assign ce_v     = {r_ce_i, l_ce_i};
    assign we_v     = {r_we_i, l_we_i};
    assign oe_v     = {r_oe_i, l_oe_i};
    assign busy_ext = {r_busy_i, l_busy_i};
    assign addr_v   = {r_addr_i, l_addr_i};
    assign wdata_v  = {r_wdata_i, l_wdata_i};

    dpram_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .ce_i    (ce_v),
        .addr_i  (addr_v),
        .match_o (match_w),
        .lose_o  (lose_v)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        ctl_t ctl;
        assign ctl         = '{ce: ce_v[p], we: we_v[p], oe: oe_v[p]};
        assign busy_eff[p] = master_i ? lose_v[p] : busy_ext[p];

        dpram_port_ctl u_ctl (
            .ctl_i   (ctl),
            .busy_i  (busy_eff[p]),
            .wr_en_o (wr_en[p]),
            .rd_en_o (rd_en[p])
        );
    end

    dpram_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .addr_i  (addr_v),
        .wdata_i (wdata_v),
        .rdata_o (rdata_v)
    );

    assign l_rdata_o = rdata_v[PORT_L];
    assign r_rdata_o = rdata_v[PORT_R];
    assign l_busy_o  = master_i && lose_v[PORT_L];
    assign r_busy_o  = master_i && lose_v[PORT_R];

    // R2: busy is only ever raised on a genuine shared-address, both-enabled cycle
    assert_busy_needs_match_R2: assert property (@(posedge clk) disable iff (rst)
        (l_busy_o || r_busy_o) |-> (l_ce_i && r_ce_i && (l_addr_i == r_addr_i)));

    // R4: never both sides busy
    assert_one_side_busy_R4: assert property (@(posedge clk) disable iff (rst)
        !(l_busy_o && r_busy_o));

    // R9: slave mode leaves busy outputs undriven-low
    assert_slave_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !master_i |-> (!l_busy_o && !r_busy_o));

    // R8: a held match keeps the loser busy
    assert_hold_left_R8: assert property (@(posedge clk) disable iff (rst)
        (master_i && $past(master_i) && $past(l_busy_o) && match_w
         && $past(match_w)) |-> l_busy_o);

    assert_hold_right_R8: assert property (@(posedge clk) disable iff (rst)
        (master_i && $past(master_i) && $past(r_busy_o) && match_w
         && $past(match_w)) |-> r_busy_o);

endmodule

// File: tb/dpram_contend_tb.sv
module dpram_contend_tb;

    localparam int AW = 4;
    localparam int DW = 8;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          master = 1'b1;
    logic          l_ce = 0, l_we = 0, l_oe = 0, l_bi = 0;
    logic          r_ce = 0, r_we = 0, r_oe = 0, r_bi = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wd = '0, r_wd = '0;
    logic [DW-1:0] l_rd, r_rd;
    logic          l_bo, r_bo;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dpram_contend #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .master_i(master),
        .l_ce_i(l_ce), .l_we_i(l_we), .l_oe_i(l_oe), .l_addr_i(l_addr),
        .l_wdata_i(l_wd), .l_rdata_o(l_rd), .l_busy_o(l_bo), .l_busy_i(l_bi),
        .r_ce_i(r_ce), .r_we_i(r_we), .r_oe_i(r_oe), .r_addr_i(r_addr),
        .r_wdata_i(r_wd), .r_rdata_o(r_rd), .r_busy_o(r_bo), .r_busy_i(r_bi)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drv_l(logic ce, logic we, logic oe, logic [AW-1:0] a, logic [DW-1:0] d);
        l_ce = ce; l_we = we; l_oe = oe; l_addr = a; l_wd = d;
    endtask

    task automatic drv_r(logic ce, logic we, logic oe, logic [AW-1:0] a, logic [DW-1:0] d);
        r_ce = ce; r_we = we; r_oe = oe; r_addr = a; r_wd = d;
    endtask

    task automatic idle();
        drv_l(0, 0, 0, '0, '0);
        drv_r(0, 0, 0, '0, '0);
    endtask

    task automatic read_l(logic [AW-1:0] a, logic [DW-1:0] exp, string tag);
        idle(); tick();
        drv_l(1, 0, 1, a, '0); tick();
        check(tag, l_rd, exp);
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R11 reset l_rdata", l_rd, 0);
        check("R11 reset r_rdata", r_rd, 0);
        check("R11 reset l_busy", l_bo, 0);
        check("R11 reset r_busy", r_bo, 0);

        // R1: left writes, right reads every address; then the reverse
        for (int a = 0; a < N; a++) begin
            drv_l(1, 1, 0, AW'(a), DW'(a * 5 + 1)); tick();
        end
        idle();
        for (int a = 0; a < N; a++) begin
            drv_r(1, 0, 1, AW'(a), '0); tick();
            check("R1 right reads left write", r_rd, DW'(a * 5 + 1));
        end
        for (int a = 0; a < N; a++) begin
            drv_r(1, 1, 0, AW'(a), DW'(a * 3 + 2)); tick();
        end
        idle();
        for (int a = 0; a < N; a++) begin
            drv_l(1, 0, 1, AW'(a), '0); tick();
            check("R1 left reads right write", l_rd, DW'(a * 3 + 2));
        end
        idle(); tick();

        // R2/R5: right parked, left arrives by address move; then mirrored
        for (int a = 0; a < N; a++) begin
            drv_l(1, 0, 1, AW'(a + 1), '0);
            drv_r(1, 1, 0, AW'(a), DW'(8'h50 + a)); tick();
            drv_l(1, 1, 0, AW'(a), DW'(8'hA0 + a));
            #1;
            check("R2 left late -> l_busy", l_bo, 1);
            check("R2 left late -> r_busy", r_bo, 0);
            tick();
            read_l(AW'(a), DW'(8'h50 + a), "R5 blocked left write");
        end
        for (int a = 0; a < N; a++) begin
            drv_r(1, 0, 1, AW'(a + 3), '0);
            drv_l(1, 1, 0, AW'(a), DW'(8'h30 + a)); tick();
            drv_r(1, 1, 0, AW'(a), DW'(8'hC0 + a));
            #1;
            check("R2 right late -> r_busy", r_bo, 1);
            check("R2 right late -> l_busy", l_bo, 0);
            tick();
            read_l(AW'(a), DW'(8'h30 + a), "R5 blocked right write");
        end

        // R3: addresses already equal, chip enable rises late
        idle(); tick();
        drv_r(1, 0, 1, 4'd5, '0);
        drv_l(0, 0, 0, 4'd5, '0); tick();
        drv_l(1, 1, 0, 4'd5, 8'hEE);
        #1;
        check("R3 left ce late -> l_busy", l_bo, 1);
        check("R3 left ce late -> r_busy", r_bo, 0);
        idle(); tick();
        drv_l(1, 0, 1, 4'd6, '0);
        drv_r(0, 0, 0, 4'd6, '0); tick();
        drv_r(1, 1, 0, 4'd6, 8'hEE);
        #1;
        check("R3 right ce late -> r_busy", r_bo, 1);
        check("R3 right ce late -> l_busy", l_bo, 0);
        idle(); tick();

        // R4: simultaneous enable arrival
        drv_l(1, 1, 0, 4'd7, 8'h11);
        drv_r(1, 1, 0, 4'd7, 8'h22);
        #1;
        check("R4 tie by ce -> r_busy", r_bo, 1);
        check("R4 tie by ce -> l_busy", l_bo, 0);
        tick();
        read_l(4'd7, 8'h11, "R4 tie left write kept");
        // R4: simultaneous address move
        drv_l(1, 0, 1, 4'd3, '0);
        drv_r(1, 0, 1, 4'd4, '0); tick();
        drv_l(1, 1, 0, 4'd9, 8'h91);
        drv_r(1, 1, 0, 4'd9, 8'h92);
        #1;
        check("R4 tie by move -> r_busy", r_bo, 1);
        check("R4 tie by move -> l_busy", l_bo, 0);
        tick();
        read_l(4'd9, 8'h91, "R4 tie-by-move left write kept");

        // R8/R7/R6: left owns addr 2, right writes and waits
        drv_l(1, 1, 0, 4'd2, 8'h55); tick();
        drv_r(1, 1, 0, 4'd2, 8'h44);
        #1;
        check("R2 right busy on arrival", r_bo, 1);
        tick();
        drv_l(1, 0, 1, 4'd2, '0);
        for (int k = 0; k < 3; k++) begin
            #1;
            check("R8 grant held after winner drops strobe", r_bo, 1);
            check("R8 winner stays free", l_bo, 0);
            tick();
        end
        drv_l(1, 0, 1, 4'd3, '0);
        #1;
        check("R7 busy falls on address split", r_bo, 0);
        tick();
        read_l(4'd2, 8'h44, "R6 held write lands after busy");

        // R7: winner chip enable falls
        drv_r(1, 0, 1, 4'd8, '0); tick();
        drv_l(1, 1, 0, 4'd8, 8'h01);
        #1;
        check("R7 left busy before release", l_bo, 1);
        tick();
        drv_r(0, 0, 0, 4'd8, '0);
        #1;
        check("R7 busy falls with winner ce", l_bo, 0);
        tick();
        read_l(4'd8, 8'h01, "R6 held left write lands");

        // R10/R5: right reads while left writes the same address
        drv_l(1, 1, 0, 4'd6, 8'h77); tick();
        drv_l(1, 1, 0, 4'd6, 8'h78);
        drv_r(1, 0, 1, 4'd6, '0);
        #1;
        check("R5 reader is busy", r_bo, 1);
        tick();
        check("R10 same-cycle read returns old", r_rd, 8'h77);
        drv_l(0, 0, 0, '0, '0);
        tick();
        check("R10 next read returns new", r_rd, 8'h78);
        idle(); tick();

        // R9: slave mode
        master = 1'b0;
        drv_r(1, 1, 0, 4'd12, 8'hB0); tick();
        drv_l(1, 1, 0, 4'd12, 8'hB1);
        r_bi = 1'b1;
        #1;
        check("R9 slave l_busy_o low", l_bo, 0);
        check("R9 slave r_busy_o low", r_bo, 0);
        tick();
        r_bi = 1'b0;
        read_l(4'd12, 8'hB1, "R9 internal grant ignored in slave");
        l_bi = 1'b1;
        drv_l(1, 1, 0, 4'd13, 8'hC1);
        drv_r(1, 1, 0, 4'd13, 8'hC2); tick();
        l_bi = 1'b0;
        read_l(4'd13, 8'hC2, "R9 busy input blocks left write");
        master = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule